// File: doc/BRIEF.md
# Four-Channel Energy Pulse Generator

This block converts signed per-interval power figures into pulse trains. Each pulse on an output stands for one fixed quantum of energy. On every sample strobe, each of four channels adds the product of its power magnitude, a shared rate constant and a fixed multiplier of 6 to a 46-bit phase accumulator. Every wrap of that accumulator past 2^46 is one quantum. A wrap queues one output pulse, and the pulse stays high for an odd number of sample periods set by a shared width register.

Software writes the four power values, the rate constant and the width through a simple write port. The power and rate values go to shadow copies and become active only on the interval-start strobe. A new figure written part-way through an interval therefore cannot disturb the interval already in progress. Each channel has a small pulse-shaping state machine with three states. SH_IDLE waits for queued quanta and moves to SH_HIGH when the queue is non-empty; this transition also takes one quantum off the queue. SH_HIGH holds the output high and counts sample strobes; it moves to SH_GAP on the last counted strobe. SH_GAP holds the output low for one sample strobe and then returns to SH_IDLE.

Top module: `enpulse_top`

## Requirements
- R1: A synchronous reset clears every accumulator, queue, output and direction flag, and clears the power shadows and the active power values to 0. It sets the rate constant to 827 and the width register to 12.
- R2: On each cycle with `tick` high, every channel adds |P| × RATE × 6 to its accumulator. P is the active signed 32-bit power and RATE is the active rate. Each crossing of a multiple of 2^46 yields one quantum, and one tick can yield several quanta.
- R3: The accumulator remainder below 2^46 is kept across wraps and across interval starts, so fractions build up into later quanta.
- R4: A write to address c (0 to 3) loads the shadow power of channel c. The active power changes only on a cycle with `ivl_start` high, when it takes the shadow value.
- R5: A write to address 4 loads the low 15 bits of `wr_data` into the rate shadow, which becomes active on the next `ivl_start`. A write whose low 15 bits are all zero is ignored.
- R6: A write to address 5 sets the width W from the low 8 bits of `wr_data`. Each pulse then stays high for exactly 2W+1 `tick` cycles.
- R7: No quantum is lost. Quanta that arrive while a pulse is running are queued, up to 255 per channel. After a pulse ends, the output stays low for exactly one `tick` before the next queued pulse starts.
- R8: `dir_o[c]` takes the sign bit of channel c's active power (1 = negative) on each tick that produces a quantum for channel c, and keeps that value otherwise.
- R9: The channels are independent. A channel with zero power produces no pulses, whatever the other channels do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample strobe, one cycle wide |
| ivl_start | input | 1 | Interval-start strobe: copies shadows to active |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | 0 to 3 channel power, 4 rate, 5 width |
| wr_data | input | 32 | Write data (power is two's complement) |
| pulse_o | output | 4 | Energy pulse per channel |
| dir_o | output | 4 | Sign of the power behind the latest quantum |

## Verification
The bench targets the remainder carry across an interval boundary: three ticks of 0.4 quantum must give exactly one pulse, and a design that cleared the accumulator at the boundary would give none. It also loads powers and rates mid-interval. A design without the double buffer would pulse before the next interval start, or would switch rate early and miscount. A burst of about six quanta per tick checks that no quantum is lost, since dropping wraps or a queue that does not count would give too few pulses. A steady backlog checks the one-tick gap, which a design that merged back-to-back pulses would fail. A zero rate write, a negative full-scale power and a reset in the middle of a pulse are also checked, for a dead rate, a wrong direction flag, and pulses that continue after the reset.

// File: rtl/enpulse_pkg.sv
package enpulse_pkg;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_HIGH,
        SH_GAP
    } shp_state_e;

    localparam int unsigned RATE_RESET  = 827;
    localparam int unsigned WIDTH_RESET = 12;

endpackage

// File: rtl/enpulse_regs.sv
module enpulse_regs #(
    parameter int NCH    = 4,
    parameter int PW_W   = 32,
    parameter int RATE_W = 15,
    parameter int WID_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [PW_W-1:0]                wr_data,
    input  logic                           ivl_start,
    output logic [NCH-1:0][PW_W-1:0]       pwr_act,
    output logic [RATE_W-1:0]              rate_act,
    output logic [WID_W-1:0]               width
);
    import enpulse_pkg::*;

    localparam logic [ADDR_W-1:0] A_RATE  = ADDR_W'(NCH);
    localparam logic [ADDR_W-1:0] A_WIDTH = ADDR_W'(NCH + 1);

    logic [NCH-1:0][PW_W-1:0] pwr_shd;
    logic [RATE_W-1:0]        rate_shd;

    for (genvar c = 0; c < NCH; c++) begin : g_pwr
        always_ff @(posedge clk) begin
            if (rst) begin
                pwr_shd[c] <= '0;
                pwr_act[c] <= '0;
            end else begin
                if (wr_en && wr_addr == ADDR_W'(c)) begin
                    pwr_shd[c] <= wr_data;
                end
                if (ivl_start) begin
                    pwr_act[c] <= pwr_shd[c];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_shd <= RATE_W'(RATE_RESET);
            rate_act <= RATE_W'(RATE_RESET);
        end else begin
            if (wr_en && wr_addr == A_RATE && wr_data[RATE_W-1:0] != '0) begin
                rate_shd <= wr_data[RATE_W-1:0];
            end
            if (ivl_start) begin
                rate_act <= rate_shd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            width <= WID_W'(WIDTH_RESET);
        end else if (wr_en && wr_addr == A_WIDTH) begin
            width <= wr_data[WID_W-1:0];
        end
    end

endmodule

// File: rtl/enpulse_accum.sv
module enpulse_accum #(
    parameter int PW_W   = 32,
    parameter int RATE_W = 15,
    parameter int MULT   = 6,
    parameter int ACC_W  = 46,
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [PW_W-1:0]   pwr,
    input  logic [RATE_W-1:0] rate,
    input  logic              take,
    output logic              pend_nz,
    output logic              dir
);
    localparam int MULT_W = $clog2(MULT + 1);
    localparam int INC_W  = PW_W + RATE_W + MULT_W;
    localparam int SUM_W  = INC_W + 1;
    localparam int Q_W    = SUM_W - ACC_W;
    localparam int PS_W   = (PEND_W > Q_W) ? PEND_W + 1 : Q_W + 1;
    localparam logic [PS_W-1:0] PEND_MAX = PS_W'((1 << PEND_W) - 1);

    logic [ACC_W-1:0]  acc;
    logic [PEND_W-1:0] pend;
    logic [PW_W-1:0]   mag;
    logic [INC_W-1:0]  inc;
    logic [SUM_W-1:0]  sum;
    logic [Q_W-1:0]    quanta;
    logic [PS_W-1:0]   grow;

    always_comb begin
        mag    = pwr[PW_W-1] ? (~pwr + 1'b1) : pwr;
        inc    = INC_W'(mag) * INC_W'(rate) * INC_W'(MULT);
        sum    = SUM_W'(acc) + SUM_W'(inc);
        quanta = sum[SUM_W-1:ACC_W];
        grow   = PS_W'(pend) + (tick ? PS_W'(quanta) : '0) - PS_W'(take);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            pend <= '0;
            dir  <= 1'b0;
        end else begin
            if (tick) begin
                acc <= sum[ACC_W-1:0];
                if (quanta != '0) begin
                    dir <= pwr[PW_W-1];
                end
            end
            pend <= (grow > PEND_MAX) ? PEND_MAX[PEND_W-1:0] : grow[PEND_W-1:0];
        end
    end

    assign pend_nz = (pend != '0);

endmodule

// File: rtl/enpulse_shaper.sv
module enpulse_shaper #(
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             pend_nz,
    input  logic [WID_W-1:0] width,
    output logic             take,
    output logic             pulse
);
    import enpulse_pkg::*;

    localparam int CNT_W = WID_W + 1;

    shp_state_e       st, nx;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SH_IDLE;
        end else begin
            st <= nx;
        end
    end

    always_comb begin
        nx = st;
        unique case (st)
            SH_IDLE: if (pend_nz) nx = SH_HIGH;
            SH_HIGH: if (tick && cnt == CNT_W'(1)) nx = SH_GAP;
            SH_GAP:  if (tick) nx = SH_IDLE;
            default: nx = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (st == SH_IDLE && pend_nz) begin
            cnt <= {width, 1'b1};
        end else if (st == SH_HIGH && tick) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        pulse = (st == SH_HIGH);
        take  = (st == SH_IDLE) && pend_nz;
    end

endmodule

// File: rtl/enpulse_top.sv
module enpulse_top #(
    parameter int NCH    = 4,
    parameter int PW_W   = 32,
    parameter int RATE_W = 15,
    parameter int WID_W  = 8,
    parameter int MULT   = 6,
    parameter int ACC_W  = 46,
    parameter int PEND_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic                       ivl_start,
    input  logic                       wr_en,
    input  logic [$clog2(NCH+2)-1:0]   wr_addr,
    input  logic [PW_W-1:0]            wr_data,
    output logic [NCH-1:0]             pulse_o,
    output logic [NCH-1:0]             dir_o
);
    localparam int ADDR_W = $clog2(NCH + 2);

    logic [NCH-1:0][PW_W-1:0] pwr_act;
    logic [RATE_W-1:0]        rate_act;
    logic [WID_W-1:0]         width;
    logic [NCH-1:0]           pend_nz;
    logic [NCH-1:0]           take;

    enpulse_regs #(
        .NCH(NCH), .PW_W(PW_W), .RATE_W(RATE_W), .WID_W(WID_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ivl_start(ivl_start),
        .pwr_act(pwr_act), .rate_act(rate_act), .width(width)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        enpulse_accum #(
            .PW_W(PW_W), .RATE_W(RATE_W), .MULT(MULT), .ACC_W(ACC_W), .PEND_W(PEND_W)
        ) u_acc (
            .clk(clk), .rst(rst), .tick(tick), .pwr(pwr_act[c]),
            .rate(rate_act), .take(take[c]), .pend_nz(pend_nz[c]), .dir(dir_o[c])
        );

        enpulse_shaper #(
            .WID_W(WID_W)
        ) u_shp (
            .clk(clk), .rst(rst), .tick(tick), .pend_nz(pend_nz[c]),
            .width(width), .take(take[c]), .pulse(pulse_o[c])
        );
    end

endmodule

// File: rtl/enpulse_chk.sv
module enpulse_chk #(
    parameter int NCH    = 4,
    parameter int PW_W   = 32,
    parameter int RATE_W = 15
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     ivl_start,
    input logic [NCH-1:0]           pulse_o,
    input logic [NCH-1:0]           pend_nz,
    input logic [NCH-1:0][PW_W-1:0] pwr_act,
    input logic [RATE_W-1:0]        rate_act
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (pulse_o == '0)); // R1

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
        !ivl_start |=> $stable(pwr_act)); // R4

    AST_RATE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        rate_act != '0); // R5

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        AST_RISE_FROM_QUEUE: assert property (@(posedge clk) disable iff (rst)
            $rose(pulse_o[c]) |-> $past(pend_nz[c])); // R7

        AST_GAP_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
            $fell(pulse_o[c]) |=> !pulse_o[c]); // R7
    end

endmodule

bind enpulse_top enpulse_chk #(.NCH(NCH), .PW_W(PW_W), .RATE_W(RATE_W)) u_chk (.*);

// File: tb/sim_enpulse_top.sv
module sim_enpulse_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_GAP   = 4;
    localparam int NCH        = 4;
    localparam longint QUANT  = 64'd1 << 46;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b0;
    logic             ivl_start = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic [NCH-1:0]   pulse_o;
    logic [NCH-1:0]   dir_o;

    int n_chk = 0;
    int n_bad = 0;
    int wd = 0;

    longint m_acc [NCH];
    longint m_q   [NCH];
    int     m_sh  [NCH];
    int     m_act [NCH];
    int     m_rate_sh, m_rate;

    int rises [NCH];
    int base  [NCH];
    int hi_t  [NCH];
    int lo_t  [NCH];
    int last_len [NCH];
    int last_gap [NCH];
    logic [NCH-1:0] prev = '0;

    enpulse_top u0 (
        .clk(clk), .rst(rst), .tick(tick), .ivl_start(ivl_start),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pulse_o(pulse_o), .dir_o(dir_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        for (int c = 0; c < NCH; c++) begin
            rises[c] = 0; hi_t[c] = 0; lo_t[c] = 0; last_len[c] = 0; last_gap[c] = 0;
        end
    end

    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (pulse_o[c]) begin
                if (!prev[c]) begin
                    rises[c]++;
                    last_gap[c] = lo_t[c];
                    hi_t[c] = 0;
                end
                if (tick) hi_t[c]++;
            end else begin
                if (prev[c]) begin
                    last_len[c] = hi_t[c];
                    lo_t[c] = 0;
                end
                if (tick) lo_t[c]++;
            end
        end
        prev = pulse_o;
    end

    task automatic show_summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL all watchdog: actual %0d cycles expected fewer", wd);
            show_summary();
            $finish;
        end
    end

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; tick = 1'b0; ivl_start = 1'b0; wr_en = 1'b0;
        cyc(); cyc();
        rst = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            m_acc[c] = 0; m_q[c] = 0; m_sh[c] = 0; m_act[c] = 0;
            base[c] = rises[c];
        end
        m_rate_sh = 827; m_rate = 827;
    endtask

    task automatic wr(int addr, logic [31:0] data);
        wr_en = 1'b1; wr_addr = addr[2:0]; wr_data = data;
        cyc();
        wr_en = 1'b0;
        if (addr < NCH) m_sh[addr] = int'(data);
        else if (addr == NCH && data[14:0] != '0) m_rate_sh = int'(data[14:0]);
    endtask

    task automatic ivl();
        ivl_start = 1'b1;
        cyc();
        ivl_start = 1'b0;
        for (int c = 0; c < NCH; c++) m_act[c] = m_sh[c];
        m_rate = m_rate_sh;
    endtask

    task automatic tick_n(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            for (int c = 0; c < NCH; c++) begin
                longint mag, s;
                mag = (m_act[c] < 0) ? -longint'(m_act[c]) : longint'(m_act[c]);
                s = m_acc[c] + mag * longint'(m_rate) * 6;
                m_q[c] += s / QUANT;
                m_acc[c] = s % QUANT;
            end
            cyc();
            tick = 1'b0;
            for (int k = 0; k < TICK_GAP - 1; k++) cyc();
        end
    endtask

    task automatic drain(int n);
        for (int c = 0; c < NCH; c++) wr(c, 32'd0);
        ivl();
        tick_n(n);
    endtask

    function automatic int got(int c);
        return rises[c] - base[c];
    endfunction

    task automatic t_reset();
        do_reset();
        check("R1 pulse_o after reset", longint'(pulse_o), 0);
        check("R1 dir_o after reset", longint'(dir_o), 0);
        wr(0, 32'h7FFF_FFFF);
        ivl();
        tick_n(10);
        drain(40);
        check("R1 default rate count ch0", got(0), m_q[0]);
        check("R1 default width length", last_len[0], 25);
        wr(4, 32'd32767);
        wr(0, 32'h7FFF_FFFF);
        ivl();
        tick_n(3);
        cyc();
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        check("R1 pulse_o low after mid-pulse reset", longint'(pulse_o), 0);
        for (int c = 0; c < NCH; c++) base[c] = rises[c];
        tick_n(30);
        check("R1 no pulses after reset", got(0), 0);
    endtask

    task automatic t_multi();
        do_reset();
        wr(5, 32'd0);
        wr(0, 32'h7FFF_FFFF);
        wr(2, -32'sd1000000000);
        ivl();
        tick_n(30);
        drain(40);
        check("R2 ch0 count", got(0), m_q[0]);
        check("R9 ch1 idle", got(1), 0);
        check("R9 ch2 count", got(2), m_q[2]);
        check("R9 ch3 idle", got(3), 0);
        do_reset();
        wr(5, 32'd0);
        wr(4, 32'd32767);
        wr(3, 32'h7FFF_FFFF);
        ivl();
        tick_n(2);
        drain(60);
        check("R2 burst count ch3", got(3), m_q[3]);
        check("R2 burst several per tick", (m_q[3] >= 10) ? 1 : 0, 1);
    endtask

    task automatic t_width();
        do_reset();
        wr(5, 32'd2);
        wr(1, 32'h7FFF_FFFF);
        ivl();
        tick_n(10);
        drain(20);
        check("R6 width 2 length", last_len[1], 5);
    endtask

    task automatic t_buffer();
        do_reset();
        wr(5, 32'd0);
        wr(0, 32'h7FFF_FFFF);
        tick_n(20);
        check("R4 shadow inactive before interval", got(0), 0);
        ivl();
        tick_n(20);
        drain(20);
        check("R4 active after interval", got(0), m_q[0]);
    endtask

    task automatic t_carry();
        do_reset();
        wr(5, 32'd0);
        wr(4, 32'd32767);
        wr(0, 32'd143165577);
        ivl();
        tick_n(2);
        for (int k = 0; k < 6; k++) cyc();
        check("R3 no pulse at 0.8 quantum", got(0), 0);
        ivl();
        tick_n(1);
        drain(10);
        check("R3 remainder carried across interval", got(0), 1);
    endtask

    task automatic t_rate();
        do_reset();
        wr(5, 32'd0);
        wr(0, 32'h7FFF_FFFF);
        ivl();
        wr(4, 32'd32767);
        tick_n(5);
        check("R5 rate change deferred", got(0), 0);
        ivl();
        tick_n(3);
        wr(4, 32'h0001_8000);
        ivl();
        tick_n(3);
        drain(100);
        check("R5 count with deferred rate and ignored zero", got(0), m_q[0]);
    endtask

    task automatic t_queue();
        do_reset();
        wr(5, 32'd1);
        wr(4, 32'd32767);
        wr(0, 32'd178956971);
        ivl();
        tick_n(24);
        drain(60);
        check("R7 no quanta lost under backlog", got(0), m_q[0]);
        check("R6 width 1 length", last_len[0], 3);
        check("R7 one-tick gap between queued pulses", last_gap[0], 1);
    endtask

    task automatic t_dir();
        do_reset();
        wr(5, 32'd0);
        wr(1, 32'h8000_0000);
        ivl();
        tick_n(15);
        drain(20);
        check("R8 dir negative ch1", dir_o[1], 1);
        check("R8 count negative ch1", got(1), m_q[1]);
        check("R8 dir ch0 untouched", dir_o[0], 0);
        wr(1, 32'h7FFF_FFFF);
        ivl();
        tick_n(15);
        drain(20);
        check("R8 dir positive ch1", dir_o[1], 0);
    endtask

    initial begin
        cyc();
        t_reset();
        t_multi();
        t_width();
        t_buffer();
        t_carry();
        t_rate();
        t_queue();
        t_dir();
        show_summary();
        $finish;
    end

endmodule